// File: doc/BRIEF.md
# Stereo PCM Serial Audio Formatter

This block turns pairs of left/right PCM samples into a three-wire serial audio stream: a channel-select clock, a bit clock and a data line. Every output edge is timed from a single master clock running at 384 times the sample rate. One stereo frame is 384 master cycles long. Each channel occupies a slot of 16, 24 or 32 bit clocks, so one bit lasts 12, 8 or 6 master cycles.

Samples enter through a valid/ready stream interface into a one-entry holding buffer. The sample in that buffer is moved into the shifter at the next frame boundary. The producer sees back-pressure: `s_ready` is low while the buffer holds a sample that has not yet moved. A transfer happens on a clock edge where `s_valid` and `s_ready` are both high. The producer must keep `s_valid` and the sample words stable until that edge. When no new sample has arrived by a frame boundary, the frame that was just sent is sent again.

The remaining controls are plain level pins, and all of them are sampled only at frame boundaries:
- the slot width code;
- sample precision (16 or 20 bits);
- left-justified or I2S framing;
- mute;
- a pass-through mode that copies an external three-wire stream to the outputs.

Top module: `audio_ser_fmt`

## Requirements
- R1: While `rst_n` is low, all three audio outputs are low and `s_ready` is high. The first frame after reset uses 16-bit slots, left-justified framing, 16-bit precision, no mute and no pass-through, and its sample words are zero.
- R2: A frame lasts 384 master cycles. Slot code 0 gives 16-bit slots with 12 cycles per bit. Code 1 gives 24-bit slots with 8 cycles per bit. Codes 2 and 3 give 32-bit slots with 6 cycles per bit. Within each bit, `aud_bck` is low for the first half of the cycles and high for the second half.
- R3: In left-justified framing (`cfg_i2s`=0), `aud_lrck` is high for the left slot and low for the right slot. The first bit of each slot carries the word MSB, and the following bits carry the next lower bits.
- R4: With `cfg_prec20`=0, the word is sample bits [19:4]. With `cfg_prec20`=1, the word is all of bits [19:0]. Slot positions beyond the word are zero. A 16-bit slot carries only the first 16 word bits.
- R5: In I2S framing (`cfg_i2s`=1), `aud_lrck` is low for the left slot. The data is the left-justified bit stream delayed by one bit clock, so the first bit of a slot carries the final bit of the slot before it.
- R6: `aud_lrck` and `aud_data` change only one master cycle after the first cycle of a bit, together with the falling edge of `aud_bck`. All outputs come from registers.
- R7: When mute is active, the words sent are zero.
- R8: When pass-through is active, each output equals the matching `thru_*` input sampled one master cycle earlier.
- R9: The mode pins take effect only at the frame boundary, which is the end of master cycle 383 of the frame. The active settings never change in the middle of a frame.
- R10: `s_ready` is high exactly when the holding buffer is empty. A sample accepted in frame N starts being sent in frame N+1.
- R11: If the buffer is empty at a frame boundary, the next frame repeats the previous sample words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 384 x sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding buffer empty, sample can be taken |
| s_left | input | 20 | Left sample, MSB-aligned |
| s_right | input | 20 | Right sample, MSB-aligned |
| cfg_slot | input | 2 | Slot width code: 0=16, 1=24, 2/3=32 |
| cfg_prec20 | input | 1 | 1 = 20-bit words, 0 = 16-bit words |
| cfg_i2s | input | 1 | 1 = I2S framing, 0 = left-justified |
| cfg_mute | input | 1 | Send zero words |
| cfg_thru | input | 1 | Copy the pass-through inputs to the outputs |
| thru_lrck | input | 1 | Pass-through channel clock |
| thru_bck | input | 1 | Pass-through bit clock |
| thru_data | input | 1 | Pass-through data |
| aud_lrck | output | 1 | Channel-select clock |
| aud_bck | output | 1 | Bit clock |
| aud_data | output | 1 | Serial data |

## Verification
The hardest case to reach from the ports is a mode change that lands in the middle of a frame while a sample is waiting in the buffer. In I2S framing this is worse when the slot width changes, because the bit delayed across the boundary belongs to a frame laid out under the old width. The stimulus therefore rewrites all mode pins at random master-cycle offsets inside frames while a producer keeps offering samples. A later phase offers samples only sparsely, and another stops them entirely, so that frame boundaries are met with a full buffer, an empty buffer and a sample arriving on the boundary cycle itself.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

  typedef enum logic [1:0] {
    SLOT16  = 2'd0,
    SLOT24  = 2'd1,
    SLOT32  = 2'd2,
    SLOT32X = 2'd3
  } slot_e;

  typedef struct packed {
    slot_e slot;
    logic  prec_hi;
    logic  i2s;
    logic  mute;
    logic  thru;
  } afmt_cfg_t;

  localparam int SLOT_MIN = 16;
  localparam int SLOT_MID = 24;
  localparam int SLOT_MAX = 32;
  localparam int PREC_LO  = 16;

endpackage

// File: rtl/afmt_timing.sv
module afmt_timing
  import afmt_pkg::*;
#(
  parameter int MCLK_RATIO = 384,
  parameter int PH_W = 4,
  parameter int BN_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  slot_e           slot,
  output logic            bck_c,
  output logic            bit_start,
  output logic            left_c,
  output logic [BN_W-1:0] slot_pos,
  output logic            frame_bnd
);

  logic [PH_W-1:0] phase, div_m1, half;
  logic [BN_W-1:0] bitn, wbits, last_bit;

  always_comb begin
    unique case (slot)
      SLOT16: begin
        div_m1   = PH_W'(MCLK_RATIO / (2 * SLOT_MIN) - 1);
        half     = PH_W'(MCLK_RATIO / (4 * SLOT_MIN));
        wbits    = BN_W'(SLOT_MIN);
        last_bit = BN_W'(2 * SLOT_MIN - 1);
      end
      SLOT24: begin
        div_m1   = PH_W'(MCLK_RATIO / (2 * SLOT_MID) - 1);
        half     = PH_W'(MCLK_RATIO / (4 * SLOT_MID));
        wbits    = BN_W'(SLOT_MID);
        last_bit = BN_W'(2 * SLOT_MID - 1);
      end
      default: begin
        div_m1   = PH_W'(MCLK_RATIO / (2 * SLOT_MAX) - 1);
        half     = PH_W'(MCLK_RATIO / (4 * SLOT_MAX));
        wbits    = BN_W'(SLOT_MAX);
        last_bit = BN_W'(2 * SLOT_MAX - 1);
      end
    endcase
  end

  assign bck_c     = (phase >= half);
  assign bit_start = (phase == '0);
  assign left_c    = (bitn < wbits);
  assign slot_pos  = left_c ? bitn : (bitn - wbits);
  assign frame_bnd = (phase == div_m1) && (bitn == last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      bitn  <= '0;
    end else if (frame_bnd) begin
      phase <= '0;
      bitn  <= '0;
    end else if (phase == div_m1) begin
      phase <= '0;
      bitn  <= bitn + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/afmt_buffer.sv
module afmt_buffer #(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right,
  input  logic          frame_bnd,
  output logic [DW-1:0] cur_l,
  output logic [DW-1:0] cur_r
);

  logic          full;
  logic [DW-1:0] hold_l, hold_r;

  assign s_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      cur_l  <= '0;
      cur_r  <= '0;
    end else begin
      if (frame_bnd && full) begin
        cur_l <= hold_l;
        cur_r <= hold_r;
      end
      if (s_valid && !full) begin
        full   <= 1'b1;
        hold_l <= s_left;
        hold_r <= s_right;
      end else if (frame_bnd) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/afmt_serializer.sv
module afmt_serializer
  import afmt_pkg::*;
#(
  parameter int DW = 20,
  parameter int BN_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  afmt_cfg_t       cfg,
  input  logic [DW-1:0]   cur_l,
  input  logic [DW-1:0]   cur_r,
  input  logic            bit_start,
  input  logic            bck_c,
  input  logic            left_c,
  input  logic [BN_W-1:0] slot_pos,
  input  logic            thru_lrck,
  input  logic            thru_bck,
  input  logic            thru_data,
  output logic            aud_lrck,
  output logic            aud_bck,
  output logic            aud_data
);

  localparam int TW = DW + SLOT_MAX;

  logic [DW-1:0] smp, word;
  logic [TW-1:0] spread;
  logic          lj_bit, prev_bit, lrck_c;

  assign smp = left_c ? cur_l : cur_r;

  always_comb begin
    if (cfg.mute)         word = '0;
    else if (cfg.prec_hi) word = smp;
    else                  word = {smp[DW-1 -: PREC_LO], {(DW - PREC_LO){1'b0}}};
  end

  // top bit after shifting = word bit (DW-1-pos), zero once pos passes the word
  assign spread = {word, {SLOT_MAX{1'b0}}} << slot_pos;
  assign lj_bit = spread[TW-1];
  assign lrck_c = cfg.i2s ? !left_c : left_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bit <= 1'b0;
      aud_lrck <= 1'b0;
      aud_bck  <= 1'b0;
      aud_data <= 1'b0;
    end else begin
      if (bit_start) prev_bit <= lj_bit;
      if (cfg.thru) begin
        aud_lrck <= thru_lrck;
        aud_bck  <= thru_bck;
        aud_data <= thru_data;
      end else begin
        aud_bck <= bck_c;
        if (bit_start) begin
          aud_lrck <= lrck_c;
          aud_data <= cfg.i2s ? prev_bit : lj_bit;
        end
      end
    end
  end

endmodule

// File: rtl/audio_ser_fmt.sv
module audio_ser_fmt
  import afmt_pkg::*;
#(
  parameter int MCLK_RATIO = 384,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right,
  input  logic [1:0]    cfg_slot,
  input  logic          cfg_prec20,
  input  logic          cfg_i2s,
  input  logic          cfg_mute,
  input  logic          cfg_thru,
  input  logic          thru_lrck,
  input  logic          thru_bck,
  input  logic          thru_data,
  output logic          aud_lrck,
  output logic          aud_bck,
  output logic          aud_data
);

  localparam int PH_W = $clog2(MCLK_RATIO / (2 * SLOT_MIN));
  localparam int BN_W = $clog2(2 * SLOT_MAX);

  afmt_cfg_t       req_cfg, act_cfg;
  logic            bck_c, bit_start, left_c, frame_bnd;
  logic [BN_W-1:0] slot_pos;
  logic [DW-1:0]   cur_l, cur_r;

  always_comb begin
    req_cfg.slot    = slot_e'(cfg_slot);
    req_cfg.prec_hi = cfg_prec20;
    req_cfg.i2s     = cfg_i2s;
    req_cfg.mute    = cfg_mute;
    req_cfg.thru    = cfg_thru;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         act_cfg <= '0;
    else if (frame_bnd) act_cfg <= req_cfg;
  end

  afmt_timing #(.MCLK_RATIO(MCLK_RATIO), .PH_W(PH_W), .BN_W(BN_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .slot(act_cfg.slot),
    .bck_c(bck_c), .bit_start(bit_start), .left_c(left_c),
    .slot_pos(slot_pos), .frame_bnd(frame_bnd)
  );

  afmt_buffer #(.DW(DW)) u_buffer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .frame_bnd(frame_bnd),
    .cur_l(cur_l), .cur_r(cur_r)
  );

  afmt_serializer #(.DW(DW), .BN_W(BN_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .cfg(act_cfg), .cur_l(cur_l), .cur_r(cur_r),
    .bit_start(bit_start), .bck_c(bck_c), .left_c(left_c), .slot_pos(slot_pos),
    .thru_lrck(thru_lrck), .thru_bck(thru_bck), .thru_data(thru_data),
    .aud_lrck(aud_lrck), .aud_bck(aud_bck), .aud_data(aud_data)
  );

endmodule

// File: rtl/afmt_checks.sv
module afmt_checks
  import afmt_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      s_valid,
  input logic      s_ready,
  input logic      frame_bnd,
  input afmt_cfg_t act_cfg,
  input logic      thru_lrck,
  input logic      thru_bck,
  input logic      thru_data,
  input logic      aud_lrck,
  input logic      aud_bck,
  input logic      aud_data
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  a_r6_lrck_on_bck_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && !$past(act_cfg.thru) && !$past(act_cfg.thru, 2) &&
     aud_lrck != $past(aud_lrck)) |-> (!aud_bck && $past(aud_bck)));

  a_r7_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act_cfg.mute && !act_cfg.i2s && !act_cfg.thru) |-> !aud_data);

  a_r8_thru_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act_cfg.thru) |-> (aud_bck == $past(thru_bck) &&
                             aud_lrck == $past(thru_lrck) &&
                             aud_data == $past(thru_data)));

  a_r9_cfg_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_bnd |=> $stable(act_cfg));

  a_r10_full_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  a_r11_empty_after_bnd: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_bnd && !(s_valid && s_ready)) |=> s_ready);

endmodule

bind audio_ser_fmt afmt_checks u_checks (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .frame_bnd(frame_bnd), .act_cfg(act_cfg),
  .thru_lrck(thru_lrck), .thru_bck(thru_bck), .thru_data(thru_data),
  .aud_lrck(aud_lrck), .aud_bck(aud_bck), .aud_data(aud_data)
);

// File: tb/tb_audio_ser_fmt.sv
`timescale 1ns/1ps
module tb_audio_ser_fmt;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [19:0] s_left = '0, s_right = '0;
  logic [1:0] cfg_slot = 2'd0;
  logic cfg_prec20 = 0, cfg_i2s = 0, cfg_mute = 0, cfg_thru = 0;
  logic thru_lrck = 0, thru_bck = 0, thru_data = 0;
  logic aud_lrck, aud_bck, aud_data;

  always #2.5 clk = ~clk;

  audio_ser_fmt dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .cfg_slot(cfg_slot),
    .cfg_prec20(cfg_prec20), .cfg_i2s(cfg_i2s), .cfg_mute(cfg_mute),
    .cfg_thru(cfg_thru), .thru_lrck(thru_lrck), .thru_bck(thru_bck),
    .thru_data(thru_data), .aud_lrck(aud_lrck), .aud_bck(aud_bck),
    .aud_data(aud_data)
  );

  int n_chk = 0, n_fail = 0;
  string ctx = "R1";
  bit live = 0, feed_on = 0, sparse = 0, thru_rand = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) %s at %0t: actual %0d expected %0d", tag, ctx, what, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // behavioural reference model
  int pos = 0, m_w = 16, m_div = 12;
  bit m_prec = 0, m_i2s = 0, m_mute = 0, m_thru = 0, m_prev = 0;
  logic [19:0] m_cl = '0, m_cr = '0;
  logic [39:0] mq[$];
  bit e_lr = 0, e_bck = 0, e_dat = 0, acc_evt = 0;

  always @(posedge clk) begin
    acc_evt = 0;
    if (!rst_n) begin
      pos = 0; m_w = 16; m_div = 12; m_prec = 0; m_i2s = 0; m_mute = 0; m_thru = 0;
      m_prev = 0; m_cl = '0; m_cr = '0; mq.delete(); e_lr = 0; e_bck = 0; e_dat = 0;
    end else begin
      int k, ph, j;
      bit left, ljb, rdy;
      logic [19:0] smp, word;
      k = pos / m_div; ph = pos % m_div;
      left = (k < m_w);
      j = left ? k : k - m_w;
      smp = left ? m_cl : m_cr;
      word = m_mute ? 20'd0 : (m_prec ? smp : {smp[19:4], 4'b0});
      ljb = (j < 20) ? word[19 - j] : 1'b0;
      if (m_thru) begin
        e_lr = thru_lrck; e_bck = thru_bck; e_dat = thru_data;
      end else begin
        e_bck = (ph >= m_div / 2);
        if (ph == 0) begin
          e_lr = m_i2s ? !left : left;
          e_dat = m_i2s ? m_prev : ljb;
        end
      end
      if (ph == 0) m_prev = ljb;
      rdy = (mq.size() == 0);
      if (pos == 383) begin
        m_w = (cfg_slot == 2'd0) ? 16 : (cfg_slot == 2'd1) ? 24 : 32;
        m_div = 384 / (2 * m_w);
        m_prec = cfg_prec20; m_i2s = cfg_i2s; m_mute = cfg_mute; m_thru = cfg_thru;
        if (mq.size() > 0) {m_cl, m_cr} = mq.pop_front();
      end
      if (s_valid && rdy) begin
        mq.push_back({s_left, s_right});
        acc_evt = 1;
      end
      pos = (pos + 1) % 384;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && live) begin
      string dtag;
      dtag = m_thru ? "R8" : m_mute ? "R7" : m_i2s ? "R5" : m_prec ? "R4" : "R3";
      chk(aud_bck === e_bck, m_thru ? "R8" : "R2", "aud_bck", aud_bck, e_bck);
      chk(aud_lrck === e_lr, m_thru ? "R8" : m_i2s ? "R5" : "R6", "aud_lrck", aud_lrck, e_lr);
      chk(aud_data === e_dat, dtag, "aud_data", aud_data, e_dat);
      chk(s_ready === (mq.size() == 0), "R10", "s_ready", s_ready, mq.size() == 0);
    end
  end

  // producer and pass-through stimulus
  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_evt || !s_valid) begin
        if (feed_on && (!sparse || $urandom_range(3) == 0)) begin
          s_valid <= 1'b1;
          s_left  <= 20'($urandom);
          s_right <= 20'($urandom);
        end else begin
          s_valid <= 1'b0;
        end
      end
      if (thru_rand) begin
        thru_lrck <= 1'($urandom);
        thru_bck  <= 1'($urandom);
        thru_data <= 1'($urandom);
      end
    end
  end

  task automatic frames(input int n);
    repeat (n * 384) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete (%s)", ctx);
    summary();
    $finish;
  end

  initial begin
    ctx = "R1";
    repeat (4) @(negedge clk);
    chk(aud_lrck === 1'b0, "R1", "aud_lrck in reset", aud_lrck, 0);
    chk(aud_bck === 1'b0, "R1", "aud_bck in reset", aud_bck, 0);
    chk(aud_data === 1'b0, "R1", "aud_data in reset", aud_data, 0);
    chk(s_ready === 1'b1, "R1", "s_ready in reset", s_ready, 1);
    rst_n = 1'b1;
    live = 1;
    frames(1);

    ctx = "R3"; feed_on = 1;
    frames(3);
    ctx = "R4"; cfg_prec20 = 1; cfg_slot = 2'd1;
    frames(3);
    cfg_slot = 2'd0;
    frames(2);
    ctx = "R5"; cfg_i2s = 1; cfg_slot = 2'd2;
    frames(3);
    ctx = "R2"; cfg_slot = 2'd3; cfg_prec20 = 0;
    frames(2);

    ctx = "R9";
    for (int i = 0; i < 8; i++) begin
      repeat (50 + $urandom_range(500)) @(negedge clk);
      cfg_slot = 2'($urandom);
      cfg_prec20 = 1'($urandom);
      cfg_i2s = 1'($urandom);
    end
    frames(1);

    ctx = "R7"; cfg_mute = 1; cfg_i2s = 0;
    frames(2);
    cfg_i2s = 1;
    frames(2);
    cfg_mute = 0;
    frames(1);

    ctx = "R11"; feed_on = 0;
    frames(3);
    ctx = "R10"; feed_on = 1; sparse = 1;
    frames(4);
    sparse = 0;

    ctx = "R8"; thru_rand = 1; cfg_thru = 1;
    frames(3);
    cfg_thru = 0;
    frames(2);
    thru_rand = 0;

    summary();
    $finish;
  end

endmodule